// File: doc/BRIEF.md
# Hart-Local Timer and Software Interrupt Unit

This block gives each processor hart in a cluster two machine-level interrupt sources: a timer interrupt driven by comparing a shared 64-bit time counter against a per-hart 64-bit compare value, and a software interrupt that any agent on the register bus can raise or clear by writing a word. The time counter runs freely from reset. It advances by one on each tick of an internal prescaler that divides the system clock down to the timebase rate; the default divisor gives a 10 MHz timebase from a 100 MHz clock.

Software reaches the block over a plain 32-bit register bus with a single-cycle request and a registered response one cycle later. The 64-bit values are split into low and high words. Software-interrupt words sit at a 4-byte stride from their region base. Compare registers sit at an 8-byte stride from their own base, with the low word first. The time counter sits at a fixed pair of read-only words. The register space is little-endian. Each hart's timer interrupt follows the comparison continuously, so it rises in the cycle in which the counter reaches the programmed value.

Top module: `hart_timer_irq`

## Requirements
- R1: After reset every software interrupt output is 0, every compare register is 0, so every timer interrupt output is 1, and `rsp_ready` is 0.
- R2: A write to the word at SOFT_BASE + 4*h sets `soft_irq[h]` to bit 0 of the written data from the cycle after the request. A read of that word returns 1 when `soft_irq[h]` is set and 0 otherwise, with bits 31:1 always zero.
- R3: The compare register of hart h has its low word at CMP_BASE + 8*h and its high word at CMP_BASE + 8*h + 4. Writing either word leaves the other word unchanged, and both words read back what was written.
- R4: `timer_irq[h]` is 1 exactly while the compare value of hart h is less than or equal to the time counter. It rises in the cycle in which the counter reaches the compare value, with no write needed, and falls after a write that moves the compare value above the counter.
- R5: The time counter reads as its low word at TIME_BASE and its high word at TIME_BASE + 4. Writes to either word have no effect on the counter.
- R6: A read of the high time word returns the upper 32 bits of the counter as captured by the most recent read of the low time word. This makes a low-then-high read pair consistent.
- R7: A request whose address has bits 1:0 nonzero, or whose address falls in no register (including words past the last hart in a region), changes no state on a write and returns 0 on a read.
- R8: For every cycle in which `req_valid` is high, `rsp_ready` is high for one cycle in the following cycle, and at no other time. Read data is valid while `rsp_ready` is high.
- R9: The time counter increases by exactly one every TICK_DIV clock cycles and never changes in any other way.
- R10: Writes that address one hart change no other hart's compare register, software interrupt or timer interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the register space |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Response strobe, one cycle after each request |
| rsp_rdata | output | 32 | Read data, valid while rsp_ready is high |
| soft_irq | output | NUM_HARTS | Machine software interrupt per hart |
| timer_irq | output | NUM_HARTS | Machine timer interrupt per hart |

## Verification
The hardest case to reach from the ports is the timer interrupt rising by itself, because nothing on the bus marks the moment and the counter is only visible through reads. The stimulus reads the counter, programs a compare value a fixed number of ticks ahead through two half-word writes ordered so that the value is never in the past, confirms the interrupt is low, and then polls the output each cycle. When the interrupt rises, the counter is read back and must equal the compare value or be one tick past it. Address handling is covered by sweeping every byte offset, aligned or not, across both per-hart regions of a three-hart instance and comparing each result with the value computed from the programmed pattern.

// File: rtl/hti_pkg.sv
package hti_pkg;

  // Widest hart index supported (up to 8 harts).
  localparam int HART_IDX_W = 3;
  localparam int TIME_W     = 64;

  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_SOFT    = 3'd1,
    ACC_CMP_LO  = 3'd2,
    ACC_CMP_HI  = 3'd3,
    ACC_TIME_LO = 3'd4,
    ACC_TIME_HI = 3'd5
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e               kind;
    logic [HART_IDX_W-1:0]   hart;
  } acc_dec_t;

endpackage

// File: rtl/hti_addr_decode.sv
module hti_addr_decode
  import hti_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          NUM_HARTS = 4,
  parameter int unsigned SOFT_BASE = 32'h0000,
  parameter int unsigned CMP_BASE  = 32'h4000,
  parameter int unsigned TIME_BASE = 32'hBFF8
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_dec_t          dec
);

  localparam logic [31:0] SOFT_SPAN = 32'(4 * NUM_HARTS);
  localparam logic [31:0] CMP_SPAN  = 32'(8 * NUM_HARTS);

  logic [31:0] addr_w;
  logic [31:0] soft_off;
  logic [31:0] cmp_off;

  assign addr_w   = 32'(addr);
  assign soft_off = addr_w - SOFT_BASE;
  assign cmp_off  = addr_w - CMP_BASE;

  always_comb begin
    dec.kind = ACC_NONE;
    dec.hart = '0;
    if (addr_w[1:0] != 2'b00) begin
      dec.kind = ACC_NONE;
    end else if (soft_off < SOFT_SPAN) begin
      dec.kind = ACC_SOFT;
      dec.hart = HART_IDX_W'(soft_off >> 2);
    end else if (cmp_off < CMP_SPAN) begin
      dec.kind = cmp_off[2] ? ACC_CMP_HI : ACC_CMP_LO;
      dec.hart = HART_IDX_W'(cmp_off >> 3);
    end else if (addr_w == TIME_BASE) begin
      dec.kind = ACC_TIME_LO;
    end else if (addr_w == TIME_BASE + 32'd4) begin
      dec.kind = ACC_TIME_HI;
    end
  end

endmodule

// File: rtl/hti_timebase.sv
module hti_timebase
  import hti_pkg::*;
#(
  parameter int unsigned TICK_DIV = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TIME_W-1:0] time_val
);

  logic tick;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] cnt_q;
      logic [DW-1:0] cnt_d;

      assign tick = (cnt_q == DW'(TICK_DIV - 1));

      always_comb begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  logic [TIME_W-1:0] time_q;
  logic [TIME_W-1:0] time_d;

  always_comb begin
    time_d = time_q + TIME_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    time_q <= '0;
    else if (tick) time_q <= time_d;
  end

  assign time_val = time_q;

endmodule

// File: rtl/hti_hart_ctx.sv
module hti_hart_ctx
  import hti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_soft,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [31:0]       wdata,
  input  logic [TIME_W-1:0] time_val,
  output logic [TIME_W-1:0] cmp_val,
  output logic              soft_pend,
  output logic              tmr_pend
);

  logic [TIME_W-1:0] cmp_q;
  logic [TIME_W-1:0] cmp_d;
  logic              soft_q;
  logic              soft_d;
  logic              cmp_en;

  assign cmp_en = wr_lo | wr_hi;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo) cmp_d[31:0]  = wdata;
    if (wr_hi) cmp_d[63:32] = wdata;
    soft_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_en) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       soft_q <= 1'b0;
    else if (wr_soft) soft_q <= soft_d;
  end

  // Live comparison every cycle against the running counter.
  assign tmr_pend  = (cmp_q <= time_val);
  assign cmp_val   = cmp_q;
  assign soft_pend = soft_q;

endmodule

// File: rtl/hart_timer_irq.sv
module hart_timer_irq
  import hti_pkg::*;
#(
  parameter int          NUM_HARTS = 4,
  parameter int          ADDR_W    = 16,
  parameter int unsigned SOFT_BASE = 32'h0000,
  parameter int unsigned CMP_BASE  = 32'h4000,
  parameter int unsigned TIME_BASE = 32'hBFF8,
  parameter int unsigned TICK_DIV  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_ready,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] soft_irq,
  output logic [NUM_HARTS-1:0] timer_irq
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [TIME_W-1:0] time_now;

  hti_timebase #(.TICK_DIV(TICK_DIV)) timebase_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .time_val (time_now)
  );

  acc_dec_t dec;

  hti_addr_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_HARTS (NUM_HARTS),
    .SOFT_BASE (SOFT_BASE),
    .CMP_BASE  (CMP_BASE),
    .TIME_BASE (TIME_BASE)
  ) decode_i (
    .addr (req_addr),
    .dec  (dec)
  );

  logic wr_req;
  logic rd_req;
  assign wr_req = req_valid & req_write;
  assign rd_req = req_valid & ~req_write;

  logic [TIME_W-1:0]    cmp_arr [NUM_HARTS];
  logic [NUM_HARTS-1:0] soft_vec;
  logic [NUM_HARTS-1:0] tmr_vec;

  generate
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic hit;
      assign hit = wr_req && (dec.hart == HART_IDX_W'(h));

      hti_hart_ctx ctx_i (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .wr_soft   (hit && (dec.kind == ACC_SOFT)),
        .wr_lo     (hit && (dec.kind == ACC_CMP_LO)),
        .wr_hi     (hit && (dec.kind == ACC_CMP_HI)),
        .wdata     (req_wdata),
        .time_val  (time_now),
        .cmp_val   (cmp_arr[h]),
        .soft_pend (soft_vec[h]),
        .tmr_pend  (tmr_vec[h])
      );
    end
  endgenerate

  // Read path: next-state selection.
  logic [31:0] rd_d;
  logic        snap_en;
  logic [31:0] snap_q;

  always_comb begin
    rd_d = '0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (dec.hart == HART_IDX_W'(h)) begin
        case (dec.kind)
          ACC_SOFT:   rd_d = {31'b0, soft_vec[h]};
          ACC_CMP_LO: rd_d = cmp_arr[h][31:0];
          ACC_CMP_HI: rd_d = cmp_arr[h][63:32];
          default:    ;
        endcase
      end
    end
    if (dec.kind == ACC_TIME_LO) rd_d = time_now[31:0];
    if (dec.kind == ACC_TIME_HI) rd_d = snap_q;
  end

  assign snap_en = rd_req && (dec.kind == ACC_TIME_LO);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  snap_q <= '0;
    else if (snap_en) snap_q <= time_now[63:32];
  end

  logic        ready_q;
  logic [31:0] rdata_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ready_q <= 1'b0;
    else             ready_q <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_d;
  end

  assign rsp_ready = ready_q;
  assign rsp_rdata = rdata_q;
  assign soft_irq  = soft_vec;
  assign timer_irq = tmr_vec;

endmodule

// File: rtl/hart_timer_irq_chk.sv
module hart_timer_irq_chk #(
  parameter int          NUM_HARTS = 4,
  parameter int          ADDR_W    = 16,
  parameter int unsigned SOFT_BASE = 32'h0000
) (
  input logic                 clk,
  input logic                 rst_ok,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 req_bit0,
  input logic                 rsp_ready,
  input logic [NUM_HARTS-1:0] soft_irq,
  input logic [NUM_HARTS-1:0] timer_irq,
  input logic [63:0]          time_val
);

  // R8
  ready_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    req_valid |=> rsp_ready);

  // R8
  ready_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_ready |-> $past(req_valid));

  // R9
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !$stable(time_val) |-> (time_val == $past(time_val) + 64'd1));

  // R7
  misaligned_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_write && (req_addr[1:0] != 2'b00)) |=> $stable(soft_irq));

  generate
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hchk
      // R2
      soft_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        (req_valid && req_write && (32'(req_addr) == SOFT_BASE + 32'(4 * h)))
        |=> (soft_irq[h] == $past(req_bit0)));

      // R4
      timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        (timer_irq[h] && !(req_valid && req_write)) |=> timer_irq[h]);
    end
  endgenerate

endmodule

bind hart_timer_irq hart_timer_irq_chk #(
  .NUM_HARTS (NUM_HARTS),
  .ADDR_W    (ADDR_W),
  .SOFT_BASE (SOFT_BASE)
) chk_i (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_bit0  (req_wdata[0]),
  .rsp_ready (rsp_ready),
  .soft_irq  (soft_irq),
  .timer_irq (timer_irq),
  .time_val  (time_now)
);

// File: tb/hart_timer_irq_tb_top.sv
module hart_timer_irq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NH         = 3;
  localparam int AW         = 16;
  localparam int DIV        = 4;
  localparam int unsigned SB = 32'h0000;
  localparam int unsigned CB = 32'h4000;
  localparam int unsigned TB = 32'hBFF8;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          rsp_ready;
  logic [31:0]   rsp_rdata;
  logic [NH-1:0] soft_irq;
  logic [NH-1:0] timer_irq;

  int errs;
  int checks;

  hart_timer_irq #(
    .NUM_HARTS (NH),
    .ADDR_W    (AW),
    .SOFT_BASE (SB),
    .CMP_BASE  (CB),
    .TIME_BASE (TB),
    .TICK_DIV  (DIV)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .soft_irq  (soft_irq),
    .timer_irq (timer_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = AW'(addr);
    req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    check("R8 ready after write", 64'(rsp_ready), 64'd1);
  endtask

  task automatic bus_read(input logic [31:0] addr, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = AW'(addr);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 ready after read", 64'(rsp_ready), 64'd1);
    data = rsp_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] t1;
    logic [31:0] t2;
    logic [31:0] t3;
    logic [31:0] cmp_lo [NH];
    logic [31:0] cmp_hi [NH];
    logic [NH-1:0] soft_exp;

    errs = 0;
    checks = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 soft_irq", 64'(soft_irq), 64'd0);
    check("R1 timer_irq", 64'(timer_irq), 64'(3'b111));
    check("R1 rsp_ready", 64'(rsp_ready), 64'd0);
    for (int h = 0; h < NH; h++) begin
      bus_read(CB + 32'(8 * h), rd);
      check("R1 cmp low reset", 64'(rd), 64'd0);
    end

    // R2: software interrupt pattern, bit 0 only
    soft_exp = '0;
    for (int h = 0; h < NH; h++) begin
      bus_write(SB + 32'(4 * h), (h % 2 == 0) ? 32'h0000_0001 : 32'hFFFF_FFFE);
      soft_exp[h] = (h % 2 == 0);
      check("R2 soft_irq after write", 64'(soft_irq), 64'(soft_exp));
    end

    // R7: misaligned and past-last-hart writes are ignored
    bus_write(SB + 32'd1, 32'hFFFF_FFFF);
    bus_write(SB + 32'd2, 32'hFFFF_FFFF);
    bus_write(SB + 32'd7, 32'hFFFF_FFFF);
    bus_write(SB + 32'(4 * NH), 32'hFFFF_FFFF);
    check("R7 soft_irq unchanged", 64'(soft_irq), 64'(soft_exp));

    // R2/R7: sweep every byte offset of the software region and beyond
    for (int a = 0; a < 32; a++) begin
      logic [31:0] e;
      e = 32'd0;
      if ((a % 4 == 0) && (a / 4 < NH)) e = 32'(soft_exp[a / 4]);
      bus_read(SB + 32'(a), rd);
      check("R2/R7 soft region read", 64'(rd), 64'(e));
    end

    // R2: clear hart 0
    bus_write(SB, 32'h0);
    soft_exp[0] = 1'b0;
    check("R2 soft clear", 64'(soft_irq), 64'(soft_exp));

    // R3: program compare values, low then high
    for (int h = 0; h < NH; h++) begin
      cmp_lo[h] = 32'hC000_0000 + 32'(h * 16);
      cmp_hi[h] = 32'h0000_00A0 + 32'(h);
      bus_write(CB + 32'(8 * h), cmp_lo[h]);
      bus_write(CB + 32'(8 * h) + 32'd4, cmp_hi[h]);
    end
    bus_write(CB + 32'd2, 32'hDEAD_BEEF);    // R7 misaligned
    bus_write(CB + 32'd5, 32'hDEAD_BEEF);    // R7 misaligned
    bus_write(CB + 32'(8 * NH), 32'hDEAD_BEEF); // R7 undecoded

    for (int a = 0; a < 32; a++) begin
      logic [31:0] e;
      e = 32'd0;
      if ((a % 4 == 0) && (a / 8 < NH)) e = ((a % 8) == 4) ? cmp_hi[a / 8] : cmp_lo[a / 8];
      bus_read(CB + 32'(a), rd);
      check("R3/R7 compare region read", 64'(rd), 64'(e));
    end

    // R4: all compares far in the future
    check("R4 timer low for future compare", 64'(timer_irq), 64'd0);

    // R10: hart 1 to zero only affects hart 1
    bus_write(CB + 32'd12, 32'h0);
    bus_write(CB + 32'd8, 32'h0);
    check("R10 only hart 1 timer", 64'(timer_irq), 64'(3'b010));
    bus_read(CB + 32'd0, rd);
    check("R10 hart 0 compare kept", 64'(rd), 64'(cmp_lo[0]));
    bus_read(CB + 32'd20, rd);
    check("R10 hart 2 compare kept", 64'(rd), 64'(cmp_hi[2]));

    // R9: 40 clock edges between samples give 10 ticks
    bus_read(TB, t1);
    repeat (38) @(negedge clk);
    bus_read(TB, t2);
    check("R9 time advance", 64'(t2 - t1), 64'd10);

    // R5: writes to the time words are ignored
    bus_write(TB, 32'hFFFF_FFF0);
    bus_write(TB + 32'd4, 32'h0000_0055);
    bus_read(TB, t3);
    check("R5 time low after write", 64'((t3 >= t2) && (t3 - t2 <= 32'd2)), 64'd1);
    bus_read(TB + 32'd4, rd);
    check("R5/R6 time high", 64'(rd), 64'd0);

    // R4: timer rises by itself when time reaches compare
    bus_read(TB, t1);
    bus_write(CB + 32'd16, t1 + 32'd40);
    bus_write(CB + 32'd20, 32'h0);
    check("R4 timer low before due", 64'(timer_irq[2]), 64'd0);
    for (int i = 0; i < 400 && !timer_irq[2]; i++) @(negedge clk);
    check("R4 timer rose", 64'(timer_irq[2]), 64'd1);
    bus_read(TB, t2);
    check("R4 rise at compare", 64'((t2 >= t1 + 32'd40) && (t2 <= t1 + 32'd41)), 64'd1);

    // R4/R3: moving compare high drops the interrupt, low word kept
    bus_write(CB + 32'd20, 32'h1);
    check("R4 timer fall on future compare", 64'(timer_irq[2]), 64'd0);
    bus_read(CB + 32'd16, rd);
    check("R3 low kept after high write", 64'(rd), 64'(t1 + 32'd40));
    bus_read(CB + 32'd20, rd);
    check("R3 high readback", 64'(rd), 64'd1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule